// File: doc/BRIEF.md
# Deficit Round-Robin Packet Arbiter

This block merges eight packet input queues onto one shared 64-bit internal data bus. It shares bus bandwidth by bytes rather than by packets. Each queue owns a credit counter counted in bus words. The scheduler visits the queues in a fixed cyclic order.

On a visit to an empty queue, that queue's credit is cleared. On a visit to a non-empty queue, the queue's quantum is added to its credit. The scheduler then compares the head packet's length against the credit. It forwards whole packets while they fit and subtracts the length of each one. Credit left over is kept for the next visit, so a queue of large packets saves up and does not crowd out queues of small packets.

The queues are first-word-fall-through, so the head packet's header word can be inspected before it is popped. A dedicated peek step converts the byte count in that word to bus words. A plain register port lets a host program each queue's quantum and read back each queue's credit.

The output is a valid/ready stream with start and end marks. While `out_valid` is high and `out_ready` is low, every output field holds its value. A packet, once started, runs to its end mark before any other queue is served; a stalled sink only delays it. Back-pressure passes straight through to the queue being served: that queue is popped only in a cycle where a word is accepted downstream.

Top module: `drr_pkt_arb`

## Requirements
- R1: After reset the scheduler starts at queue 0 and visits queues in the order 0, 1, ..., 7, 0, ...; `out_src` gives the queue number of the word on the bus.
- R2: A visit that finds a queue with `in_valid` low sets that queue's credit to 0.
- R3: A visit to a non-empty queue adds that queue's quantum to its credit before any word is sent.
- R4: The head packet is forwarded only when its length in words is no more than the current credit, and that length is then subtracted from the credit.
- R5: After each forwarded packet, the same queue's next packet is checked against the remaining credit. The scheduler moves to the next queue only when the queue is empty or the packet does not fit.
- R6: Credit that is not used stays with a non-empty queue across visits, so a packet longer than one quantum goes out after enough visits.
- R7: The packet length is the byte count in bits [15:0] of the header word (the word with `in_sop` high). It is converted to words as ceil(bytes/8), and a count of 0 is treated as 1 word.
- R8: Output words of one packet are contiguous and come from one queue, with `out_sop` on the first word and `out_eop` on the last. While `out_valid` is high and `out_ready` is low, all output fields hold. The cycle after an end word is accepted has `out_valid` low.
- R9: Host port: `reg_addr[3]`=1 selects the quantum of queue `reg_addr[2:0]`, which is written when `reg_wr` is high and can be read back. `reg_addr[3]`=0 selects that queue's credit, which is read-only. `reg_rdata` is combinational. Reset values: quantum 24, credit 0.
- R10: Credit saturates at 16'hFFFF instead of wrapping when the quantum is added.
- R11: At most one `in_ready` bit is high. It is high only for the queue being served, in a cycle where a word is accepted at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Per-queue head word present |
| in_data | input | 512 | Per-queue head word, queue i in bits [64i+63:64i] |
| in_sop | input | 8 | Per-queue head word is a packet header |
| in_eop | input | 8 | Per-queue head word is a packet's last word |
| in_ready | output | 8 | Per-queue pop strobe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts output word |
| out_data | output | 64 | Output word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_src | output | 3 | Queue the word came from |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 4 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data |

## Verification
A wrong credit value shows on the host read port in the same cycle the counter is updated. At the output it shows by the next visit to that queue: packets go out in a different order or on a later round than the byte budget allows. A scheduler pointer that skips or repeats a queue shows as a changed order of `out_src` values within one round. A faulty length conversion shows as a packet being held back or let through one visit early. A broken handshake shows at once as a word changing under back-pressure, a duplicated or lost word, or an end mark followed by a valid word in the next cycle.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [1:0] {
    ST_VISIT = 2'd0,
    ST_PEEK  = 2'd1,
    ST_SEND  = 2'd2
  } arb_st_e;
endpackage

// File: rtl/drr_len_decode.sv
module drr_len_decode #(
  parameter int DW = 64,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic [DW-1:0] head,
  output logic [CW-1:0] words
);
  localparam int WB  = DW / 8;
  localparam int WBL = $clog2(WB);

  logic [LW:0]   sum;
  logic [CW-1:0] rounded;

  // bytes rounded up to whole bus words
  assign sum     = {1'b0, head[LW-1:0]} + (LW+1)'(WB - 1);
  assign rounded = CW'(sum >> WBL);
  assign words   = (rounded == '0) ? CW'(1) : rounded;
endmodule

// File: rtl/drr_credit_bank.sv
module drr_credit_bank #(
  parameter int NQ   = 8,
  parameter int CW   = 16,
  parameter int QDEF = 24,
  localparam int IW  = $clog2(NQ)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  idx,
  input  logic           clr,
  input  logic           add,
  input  logic           sub,
  input  logic [CW-1:0]  sub_amt,
  input  logic           hw_en,
  input  logic [IW-1:0]  hw_idx,
  input  logic [CW-1:0]  hw_data,
  output logic [NQ*CW-1:0] credit_flat,
  output logic [NQ*CW-1:0] quant_flat
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [CW-1:0] cr;
    logic [CW-1:0] qt;
    logic [CW:0]   sum;
    logic [CW-1:0] cr_sat;

    assign sum    = {1'b0, cr} + {1'b0, qt};
    assign cr_sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cr <= '0;
        qt <= CW'(QDEF);
      end else begin
        if (hw_en && hw_idx == IW'(g)) qt <= hw_data;
        if (idx == IW'(g)) begin
          if (clr)      cr <= '0;
          else if (add) cr <= cr_sat;
          else if (sub) cr <= cr - sub_amt;
        end
      end
    end

    assign credit_flat[g*CW +: CW] = cr;
    assign quant_flat[g*CW +: CW]  = qt;
  end
endmodule

// File: rtl/drr_sched.sv
module drr_sched
  import drr_pkg::*;
#(
  parameter int NQ  = 8,
  parameter int CW  = 16,
  localparam int IW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_valid,
  input  logic          sel_eop,
  input  logic [CW-1:0] head_words,
  input  logic [CW-1:0] credit,
  input  logic          out_ready,
  output logic [IW-1:0] idx,
  output logic          cr_clr,
  output logic          cr_add,
  output logic          cr_sub,
  output logic          sending
);
  arb_st_e       st, st_n;
  logic [IW-1:0] idx_n, nxt;

  assign nxt     = (idx == IW'(NQ - 1)) ? '0 : idx + 1'b1;
  assign sending = (st == ST_SEND);

  always_comb begin
    st_n   = st;
    idx_n  = idx;
    cr_clr = 1'b0;
    cr_add = 1'b0;
    cr_sub = 1'b0;
    unique case (st)
      ST_VISIT: begin
        if (!sel_valid) begin
          cr_clr = 1'b1;
          idx_n  = nxt;
        end else begin
          cr_add = 1'b1;
          st_n   = ST_PEEK;
        end
      end
      ST_PEEK: begin
        if (sel_valid && head_words <= credit) begin
          cr_sub = 1'b1;
          st_n   = ST_SEND;
        end else begin
          idx_n = nxt;
          st_n  = ST_VISIT;
        end
      end
      ST_SEND: begin
        if (sel_valid && out_ready && sel_eop) st_n = ST_PEEK;
      end
      default: st_n = ST_VISIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_VISIT;
      idx <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
    end
  end
endmodule

// File: rtl/drr_pkt_arb.sv
module drr_pkt_arb #(
  parameter int NQ   = 8,
  parameter int DW   = 64,
  parameter int CW   = 16,
  parameter int LW   = 16,
  parameter int QDEF = 24,
  localparam int IW  = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    in_valid,
  input  logic [NQ*DW-1:0] in_data,
  input  logic [NQ-1:0]    in_sop,
  input  logic [NQ-1:0]    in_eop,
  output logic [NQ-1:0]    in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [IW-1:0]    out_src,
  input  logic             reg_wr,
  input  logic [IW:0]      reg_addr,
  input  logic [CW-1:0]    reg_wdata,
  output logic [CW-1:0]    reg_rdata
);
  logic [IW-1:0]    idx;
  logic             sel_valid, sel_eop, sending;
  logic [DW-1:0]    sel_data;
  logic [CW-1:0]    head_words, cur_credit;
  logic             cr_clr, cr_add, cr_sub;
  logic [NQ*CW-1:0] credit_flat, quant_flat;

  assign sel_valid  = in_valid[idx];
  assign sel_eop    = in_eop[idx];
  assign sel_data   = in_data[idx*DW +: DW];
  assign cur_credit = credit_flat[idx*CW +: CW];

  drr_len_decode #(.DW(DW), .LW(LW), .CW(CW)) u_len (
    .head  (sel_data),
    .words (head_words)
  );

  drr_sched #(.NQ(NQ), .CW(CW)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_valid  (sel_valid),
    .sel_eop    (sel_eop),
    .head_words (head_words),
    .credit     (cur_credit),
    .out_ready  (out_ready),
    .idx        (idx),
    .cr_clr     (cr_clr),
    .cr_add     (cr_add),
    .cr_sub     (cr_sub),
    .sending    (sending)
  );

  drr_credit_bank #(.NQ(NQ), .CW(CW), .QDEF(QDEF)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx         (idx),
    .clr         (cr_clr),
    .add         (cr_add),
    .sub         (cr_sub),
    .sub_amt     (head_words),
    .hw_en       (reg_wr && reg_addr[IW]),
    .hw_idx      (reg_addr[IW-1:0]),
    .hw_data     (reg_wdata),
    .credit_flat (credit_flat),
    .quant_flat  (quant_flat)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_pop
    assign in_ready[g] = sending && sel_valid && out_ready && (idx == IW'(g));
  end

  assign out_valid = sending && sel_valid;
  assign out_data  = sel_data;
  assign out_sop   = in_sop[idx];
  assign out_eop   = sel_eop;
  assign out_src   = idx;

  assign reg_rdata = reg_addr[IW] ? quant_flat[reg_addr[IW-1:0]*CW +: CW]
                                  : credit_flat[reg_addr[IW-1:0]*CW +: CW];
endmodule

// File: rtl/drr_pkt_arb_chk.sv
module drr_pkt_arb_chk #(
  parameter int NQ  = 8,
  parameter int DW  = 64,
  localparam int IW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sop,
  input logic          out_eop,
  input logic [IW-1:0] out_src
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_src)
                                && $stable(out_sop) && $stable(out_eop));

  // R8
  pkt_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eop |=> $stable(out_src));

  // R8
  eop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> !out_valid);

  // R11
  onehot_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  // R11
  pop_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready != '0) |-> out_valid && out_ready && in_ready[out_src]);
endmodule

bind drr_pkt_arb drr_pkt_arb_chk #(.NQ(NQ), .DW(DW)) u_chk (.*);

// File: tb/tb_drr_pkt_arb.sv
module tb_drr_pkt_arb;
  localparam int NQ = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NQ-1:0]    in_valid, in_sop, in_eop, in_ready;
  logic [NQ*DW-1:0] in_data;
  logic             out_valid, out_sop, out_eop;
  logic             out_ready = 1'b1;
  logic [DW-1:0]    out_data;
  logic [2:0]       out_src;
  logic             reg_wr = 1'b0;
  logic [3:0]       reg_addr = '0;
  logic [15:0]      reg_wdata = '0;
  logic [15:0]      reg_rdata;

  drr_pkt_arb dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // queue models: first-word-fall-through
  logic [DW-1:0] qmem [NQ][256];
  logic          qsop [NQ][256];
  logic          qeop [NQ][256];
  int wr_p [NQ];
  int rd_p [NQ];
  int lim  [NQ];

  always @(posedge clk or negedge rst_n)
    for (int i = 0; i < NQ; i++)
      if (!rst_n) rd_p[i] <= 0;
      else if (in_valid[i] && in_ready[i]) rd_p[i] <= rd_p[i] + 1;

  always_comb
    for (int i = 0; i < NQ; i++) begin
      in_valid[i]          = (rd_p[i] < wr_p[i]) && (rd_p[i] < lim[i]);
      in_data[i*DW +: DW]  = qmem[i][rd_p[i] & 255];
      in_sop[i]            = qsop[i][rd_p[i] & 255];
      in_eop[i]            = qeop[i][rd_p[i] & 255];
    end

  // sink with optional back-pressure, and output log
  bit bp = 1'b0;
  int cyc = 0;
  logic [2:0]    lg_src [1024];
  logic [DW-1:0] lg_dat [1024];
  logic          lg_sop [1024];
  logic          lg_eop [1024];
  int lg_n = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    out_ready = bp ? (cyc % 3 != 2) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      lg_src[lg_n & 1023] = out_src;
      lg_dat[lg_n & 1023] = out_data;
      lg_sop[lg_n & 1023] = out_sop;
      lg_eop[lg_n & 1023] = out_eop;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nwords(input int bytes);
    int n = (bytes + 7) / 8;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [63:0] gw(input int q, input int p, input int k, input int b);
    if (k == 0) return {8'(q), 8'(p), 32'h5A5A_0000, 16'(b)};
    return {8'(q), 8'(p), 16'(k), 32'hC0DE_0000};
  endfunction

  task automatic push_pkt(input int q, input int p, input int b);
    int n = nwords(b);
    for (int k = 0; k < n; k++) begin
      qmem[q][(wr_p[q] + k) & 255] = gw(q, p, k, b);
      qsop[q][(wr_p[q] + k) & 255] = (k == 0);
      qeop[q][(wr_p[q] + k) & 255] = (k == n - 1);
    end
    wr_p[q] = wr_p[q] + n;
  endtask

  int base = 0;

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bp = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      wr_p[i] = 0;
      lim[i]  = 1000;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    base = lg_n;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_words(input int n);
    for (int t = 0; t < 3000 && (lg_n - base) < n; t++) @(negedge clk);
  endtask

  task automatic expect_pkt(inout int pos, input int q, input int p, input int b, input string tag);
    int n = nwords(b);
    for (int k = 0; k < n; k++) begin
      int j = (base + pos) & 1023;
      logic [67:0] act = {lg_src[j], lg_sop[j], lg_eop[j], lg_dat[j]};
      logic [67:0] exp = {3'(q), k == 0, k == n - 1, gw(q, p, k, b)};
      chk(act == exp && (pos < lg_n - base), tag, act[63:0], exp[63:0]);
      pos++;
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic poll_cr(input int q, input logic [15:0] prev, output logic [15:0] v);
    reg_addr = {1'b0, 3'(q)};
    v = prev;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (reg_rdata != prev) begin
        v = reg_rdata;
        return;
      end
    end
  endtask

  // reset state, R9 defaults
  task automatic t_reset();
    logic [15:0] v;
    hold_reset();
    chk(out_valid == 1'b0 && in_ready == '0, "R8 reset outputs idle", {out_valid, in_ready}, 0);
    rd_reg(4'h0, v);
    chk(v == 16'd0, "R9 reset credit q0", v, 0);
    rd_reg(4'hD, v);
    chk(v == 16'd24, "R9 reset quantum q5", v, 24);
    release_reset();
  endtask

  // carry-over of credit for an oversize packet, rounding, clearing
  task automatic t_carry();
    logic [15:0] v;
    int pos = 0;
    hold_reset();
    push_pkt(0, 1, 8);    // 1 word
    push_pkt(0, 2, 9);    // 2 words, rounded up (R7)
    push_pkt(1, 3, 200);  // 25 words, exceeds one quantum
    release_reset();
    poll_cr(1, 16'd0, v);
    chk(v == 16'd24, "R3 first visit adds quantum", v, 24);
    poll_cr(1, v, v);
    chk(v == 16'd48, "R6 credit carried to next visit", v, 48);
    poll_cr(1, v, v);
    chk(v == 16'd23, "R4 length subtracted from credit", v, 23);
    wait_words(28);
    expect_pkt(pos, 0, 1, 8, "R1 R7 q0 first packet");
    expect_pkt(pos, 0, 2, 9, "R7 q0 second packet two words");
    expect_pkt(pos, 1, 3, 200, "R6 q1 large packet on second visit");
    repeat (40) @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      rd_reg({1'b0, 3'(q)}, v);
      chk(v == 16'd0, "R2 empty visit clears credit", v, 0);
    end
    chk(lg_n - base == 28, "R4 no extra words", lg_n - base, 28);
  endtask

  // move on when the next packet no longer fits
  task automatic t_fit();
    int pos = 0;
    hold_reset();
    push_pkt(0, 1, 160); // 20 words
    push_pkt(0, 2, 80);  // 10 words, does not fit the 4 left
    push_pkt(1, 3, 8);
    release_reset();
    wait_words(31);
    expect_pkt(pos, 0, 1, 160, "R5 q0 first packet");
    expect_pkt(pos, 1, 3, 8, "R5 q1 served before q0 remainder");
    expect_pkt(pos, 0, 2, 80, "R5 q0 second packet next round");
  endtask

  // back-pressure on the output
  task automatic t_bp();
    int pos = 0;
    hold_reset();
    push_pkt(5, 7, 17);
    push_pkt(4, 6, 24);
    bp = 1'b1;
    release_reset();
    wait_words(6);
    expect_pkt(pos, 4, 6, 24, "R8 R11 q4 under back-pressure");
    expect_pkt(pos, 5, 7, 17, "R8 R1 q5 after q4");
    repeat (20) @(negedge clk);
    chk(lg_n - base == 6, "R11 no duplicated words", lg_n - base, 6);
    bp = 1'b0;
  endtask

  // programmed quantum
  task automatic t_quantum();
    logic [15:0] v;
    int pos = 0;
    hold_reset();
    push_pkt(2, 9, 40); // 5 words
    lim[2] = 0;
    release_reset();
    wr_reg(4'hA, 16'd4);
    rd_reg(4'hA, v);
    chk(v == 16'd4, "R9 quantum readback", v, 4);
    rd_reg(4'hF, v);
    chk(v == 16'd24, "R9 other quantum untouched", v, 24);
    wr_reg(4'h2, 16'h1234);
    rd_reg(4'h2, v);
    chk(v == 16'd0, "R9 credit not writable", v, 0);
    lim[2] = 1000;
    poll_cr(2, 16'd0, v);
    chk(v == 16'd4, "R3 programmed quantum added", v, 4);
    poll_cr(2, v, v);
    chk(v == 16'd8, "R6 programmed credit carried", v, 8);
    poll_cr(2, v, v);
    chk(v == 16'd3, "R4 subtract after programmed quantum", v, 3);
    wait_words(5);
    expect_pkt(pos, 2, 9, 40, "R6 q2 packet after two visits");
  endtask

  // saturation
  task automatic t_sat();
    logic [15:0] v;
    hold_reset();
    push_pkt(3, 1, 8);
    push_pkt(3, 2, 8);
    lim[3] = 0;
    release_reset();
    wr_reg(4'hB, 16'hFFF0);
    lim[3] = 1;
    poll_cr(3, 16'd0, v);
    chk(v == 16'hFFF0, "R3 large quantum added", v, 16'hFFF0);
    poll_cr(3, v, v);
    chk(v == 16'hFFEF, "R4 one word subtracted", v, 16'hFFEF);
    repeat (4) @(negedge clk);
    lim[3] = 1000;
    poll_cr(3, v, v);
    chk(v == 16'hFFFF, "R10 credit saturates", v, 16'hFFFF);
    poll_cr(3, v, v);
    chk(v == 16'hFFFE, "R10 R4 subtract from saturated", v, 16'hFFFE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin
      wr_p[i] = 0;
      lim[i]  = 1000;
      for (int k = 0; k < 256; k++) begin
        qmem[i][k] = '0;
        qsop[i][k] = 1'b0;
        qeop[i][k] = 1'b0;
      end
    end
    t_reset();
    t_carry();
    t_fit();
    t_bp();
    t_quantum();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule